// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block watches over software by counting clock cycles. If software does not clear the count before it reaches the chosen expiry point, the block requests a system reset. The request is a single-cycle pulse. As an alternative, software can switch the block into interval mode. In that mode each expiry gives a one-cycle interrupt pulse and the count keeps running, which provides a periodic tick. The block runs in watchdog mode as soon as power-on reset is released, so no setup write is needed to arm it.

All control goes through one 16-bit register. A write takes effect only when its upper byte carries the key 8'h5A. A write with any other upper byte counts as a software fault and triggers a reset request at once. A read returns a fixed signature byte above the current control bits.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset `rd_data` reads 16'h6900 and `rst_req` and `irq` are low. The block is then in watchdog mode with hold off and select 00, and the count is 0.
- R2: `rd_data[15:8]` always reads 8'h69. `rd_data[7:0]` holds the control bits: bit 7 is hold, bit 4 is mode (1 = interval), bits 1:0 are select, and bits 6, 5, 3 and 2 read 0.
- R3: A write with `wr_data[15:8]` = 8'h5A loads hold from bit 7, mode from bit 4 and select from bits 1:0. It does not cause a reset request.
- R4: A write whose upper byte is not 8'h5A raises `rst_req` for exactly one cycle after that edge. It also returns every control bit to 0 and sets the count to 0.
- R5: A keyed write with bit 3 set makes the count 0. Bit 3 is never stored and always reads 0.
- R6: Select 00, 01, 10 and 11 place expiry when the count reaches 2^15-1, 2^13-1, 2^9-1 and 2^6-1. The period with no writes is therefore 2^15, 2^13, 2^9 and 2^6 cycles.
- R7: While hold is 1, the count does not advance and no expiry occurs.
- R8: In watchdog mode an expiry raises `rst_req` for one cycle. It also returns all control bits to 0 and sets the count to 0.
- R9: In interval mode an expiry raises `irq` for one cycle and restarts the count from 0. The control bits are left unchanged, and `rst_req` stays low.
- R10: Expiry is taken whenever the count is at or above the selected limit. Choosing a shorter interval while the count is already past the new limit therefore expires on the next cycle that is not a write.
- R11: A clock cycle with `wr_en` high never advances the count and never expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 16 | Write data: key in the upper byte, control bits in the lower byte |
| rd_data | output | 16 | Read data: signature byte above the control bits |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interval interrupt |

## Verification
The assertions assume that `wr_en` and `wr_data` are stable around each rising edge. They also assume that a reset request is simply reported and does not restart the block, since the system reset logic lies outside it. The bench changes inputs only on falling edges and leaves `rst_n` high after the first release. This means every expiry and every keyed or unkeyed write is seen by the block and by the reference model on the same edge.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int CW = 16,
  parameter int TAP0 = 15,
  parameter int TAP1 = 13,
  parameter int TAP2 = 9,
  parameter int TAP3 = 6,
  parameter logic [7:0] KEY = 8'h5A,
  parameter logic [7:0] SIG = 8'h69
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        rst_req,
  output logic        irq
);
  localparam int HOLD_B = 7;
  localparam int MODE_B = 4;
  localparam int CLR_B  = 3;
  localparam logic [CW-1:0] ONES = {CW{1'b1}};

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          hold_q, mode_q;
  logic [1:0]    sel_q;

  wire key_ok  = wr_data[15:8] == KEY;
  wire good_wr = wr_en && key_ok;
  wire bad_wr  = wr_en && !key_ok;

  always_comb begin
    case (sel_q)
      2'd0:    lim = ONES >> (CW - TAP0);
      2'd1:    lim = ONES >> (CW - TAP1);
      2'd2:    lim = ONES >> (CW - TAP2);
      default: lim = ONES >> (CW - TAP3);
    endcase
  end

  wire expire = !wr_en && !hold_q && (cnt >= lim);

  assign rd_data = {SIG, hold_q, 2'b00, mode_q, 2'b00, sel_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hold_q  <= 1'b0;
      mode_q  <= 1'b0;
      sel_q   <= 2'd0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      irq     <= 1'b0;
      if (bad_wr) begin
        rst_req <= 1'b1;
        cnt     <= '0;
        hold_q  <= 1'b0;
        mode_q  <= 1'b0;
        sel_q   <= 2'd0;
      end else if (good_wr) begin
        hold_q <= wr_data[HOLD_B];
        mode_q <= wr_data[MODE_B];
        sel_q  <= wr_data[1:0];
        if (wr_data[CLR_B]) cnt <= '0;
      end else if (expire) begin
        cnt <= '0;
        if (mode_q) begin
          irq <= 1'b1;
        end else begin
          rst_req <= 1'b1;
          hold_q  <= 1'b0;
          mode_q  <= 1'b0;
          sel_q   <= 2'd0;
        end
      end else if (!hold_q) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_badkey_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> rst_req && (rd_data[7:0] == 8'h00) && (cnt == '0));
  assert_goodkey_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> !rst_req && !irq);
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr && wr_data[CLR_B] |=> cnt == '0);
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !wr_en |=> $stable(cnt) && !rst_req && !irq);
  assert_wdog_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rd_data[7:0] == 8'h00);
  assert_interval_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_data[MODE_B] && !rst_req && cnt == '0);
  assert_write_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr && !wr_data[CLR_B] |=> $stable(cnt));
endmodule

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/100ps
module wdt_keyed_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        rst_req, irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  int m_cnt = 0;
  bit m_hold = 0, m_mode = 0, m_rst = 0, m_irq = 0;
  int m_sel = 0;
  int taps[4] = '{15, 13, 9, 6};

  always #2.5 clk = ~clk;

  wdt_keyed u_wdt_keyed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rst_req(rst_req), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_mode = 0; m_sel = 0; m_rst = 0; m_irq = 0;
    end else begin
      int lim;
      lim = (1 << taps[m_sel]) - 1;
      m_rst = 0; m_irq = 0;
      if (wr_en && wr_data[15:8] != 8'h5A) begin
        m_rst = 1; m_cnt = 0; m_hold = 0; m_mode = 0; m_sel = 0;
      end else if (wr_en) begin
        m_hold = wr_data[7]; m_mode = wr_data[4]; m_sel = wr_data[1:0];
        if (wr_data[3]) m_cnt = 0;
      end else if (!m_hold) begin
        if (m_cnt >= lim) begin
          m_cnt = 0;
          if (m_mode) m_irq = 1;
          else begin m_rst = 1; m_mode = 0; m_sel = 0; end
        end else m_cnt++;
      end
    end
  end

  function automatic logic [15:0] m_rd();
    return {8'h69, m_hold, 2'b00, m_mode, 2'b00, 2'(m_sel)};
  endfunction

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", t, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({tag, " rd_data"}, rd_data, m_rd());
      chk({tag, " rst_req"}, {15'd0, rst_req}, {15'd0, m_rst});
      chk({tag, " irq"}, {15'd0, irq}, {15'd0, m_irq});
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 16'h0000;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1 reset rd_data", rd_data, 16'h6900);
    chk("R1 reset outputs", {14'd0, rst_req, irq}, 16'h0000);
    tag = "R8"; idle(32800);
    tag = "R3"; wr(16'h5A11);
    chk("R3 keyed write loads", rd_data, 16'h6911);
    chk("R2 signature", {8'h00, rd_data[15:8]}, 16'h0069);
    tag = "R5"; wr(16'h5A0B);
    chk("R5 clear reads zero", rd_data, 16'h6903);
    tag = "R6"; idle(300);
    tag = "R9"; wr(16'h5A13); idle(200);
    chk("R9 interval keeps ctl", rd_data, 16'h6913);
    tag = "R7"; wr(16'h5A93); idle(150);
    chk("R7 hold no irq", {15'd0, irq}, 16'h0000);
    tag = "R10"; wr(16'h5A10); idle(600);
    wr(16'h5A12); idle(1100);
    tag = "R11"; repeat (20) wr(16'h5A13);
    wr(16'h5A02); idle(520);
    tag = "R4"; wr(16'h5A13); idle(10);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h1234;
    @(negedge clk); wr_en = 1'b0; wr_data = 16'h0000;
    chk("R4 bad key reset pulse", {15'd0, rst_req}, 16'h0001);
    chk("R4 bad key defaults", rd_data, 16'h6900);
    @(negedge clk);
    chk("R4 pulse one cycle", {15'd0, rst_req}, 16'h0000);
    tag = "R6"; wr(16'h5A01); idle(8300);
    finish_run();
  end
endmodule